// File: doc/BRIEF.md
# Loop Abort Arbiter

This block decides when an abort request may cut short a loop running on the instruction stage of a dock. The abort arrives on a destination port of its own, separate from the data and instruction queues. Anything that shows up there counts as an abort, whether it carries a data word or is a bare token. The block latches one such request as pending. It stops accepting further requests until the pending one has been used.

A pending abort fires only when the instruction on deck can be interrupted. That means it is a move with its interruptible bit set, its predicate true and the outer loop count positive, and it is still stalled on at least one of its three wait conditions. When it fires, the block gives a one-cycle clear that the loop controller uses to zero both loop counters and, as a result, unseal the hatch. In the same cycle the port becomes ready again.

The abort takes precedence over normal completion. If the instruction finishes in the very cycle it becomes interruptible, the clear still fires. A squash pulse also tells the deck not to re-enqueue the interrupted instruction.

Top module: `torpedo_arbiter`

## Requirements
- R1: While and after reset, with no request accepted, `loop_clear` and `od_squash` are low and `trp_ready` is high.
- R2: A request is accepted in a cycle where `trp_valid` and `trp_ready` are both high. From the next cycle `trp_ready` is low, and it stays low, ignoring `trp_valid`, until the clear fires.
- R3: A pending request stays pending, with no clear, while any condition for an interruptible instruction is missing. The conditions are: `od_valid`, `od_opcode` equal to the move code (default 3'b001), `od_intr`, `od_pred`, `od_outer_pos`, and at least one bit of `od_wait` set.
- R4: Any one of the three `od_wait` bits (bit 0 waiting on a token, bit 1 waiting on input data, bit 2 waiting on output space) is enough to make the instruction interruptible.
- R5: If a request is pending in a cycle where the instruction is interruptible, `loop_clear` is high in the next cycle for exactly one cycle.
- R6: `trp_ready` is high again in the same cycle that `loop_clear` is high. A new request can be accepted at once.
- R7: `loop_clear` never rises unless a request was pending in the cycle before.
- R8: If `od_done` is high in the cycle the clear is decided, the clear still fires and `od_squash` is high together with it. Otherwise `od_squash` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trp_valid | input | 1 | An abort item (data or token) is offered |
| trp_ready | output | 1 | The single-entry abort slot is free |
| od_valid | input | 1 | An instruction occupies the deck |
| od_opcode | input | OPC_W | Opcode of the instruction on deck |
| od_intr | input | 1 | Interruptible bit of the instruction on deck |
| od_pred | input | 1 | Predicate of the instruction on deck is true |
| od_outer_pos | input | 1 | Outer loop counter is above zero |
| od_wait | input | WAIT_W | Wait conditions: token, input data, output space |
| od_done | input | 1 | The instruction on deck completes normally this cycle |
| loop_clear | output | 1 | One-cycle pulse: zero both loop counters |
| od_squash | output | 1 | With the clear: drop the completing instruction, no re-enqueue |

## Verification
The checker assumes that the deck status inputs describe the current cycle's instruction. It does not model how that instruction evolves, so an interruptible cycle with an abort pending must always lead to a clear, whatever the deck does next. It also assumes `trp_valid` may stay high while the slot is full. The stimulus changes inputs only on the falling edge. It deliberately keeps `trp_valid` asserted through a pending period, and it removes each eligibility condition one at a time, so every blocking condition is shown on its own.

// File: rtl/torpedo_pkg.sv
package torpedo_pkg;
  localparam int unsigned WAIT_TOKEN = 0;
  localparam int unsigned WAIT_DIN   = 1;
  localparam int unsigned WAIT_DOUT  = 2;

  typedef struct packed {
    logic fire;
    logic squash;
  } trp_evt_t;
endpackage

// File: rtl/trp_eligibility.sv
module trp_eligibility #(
  parameter int unsigned OPC_W    = 3,
  parameter logic [OPC_W-1:0] MOVE_OPC = 3'b001,
  parameter int unsigned WAIT_W   = 3
) (
  input  logic              od_valid,
  input  logic [OPC_W-1:0]  od_opcode,
  input  logic              od_intr,
  input  logic              od_pred,
  input  logic              od_outer_pos,
  input  logic [WAIT_W-1:0] od_wait,
  output logic              interruptible
);
  logic [WAIT_W:0] wait_chain;

  assign wait_chain[0] = 1'b0;
  for (genvar g = 0; g < WAIT_W; g++) begin : g_wait
    assign wait_chain[g+1] = wait_chain[g] | od_wait[g];
  end

  always_comb begin
    interruptible = od_valid && (od_opcode == MOVE_OPC) && od_intr &&
                    od_pred && od_outer_pos && wait_chain[WAIT_W];
  end
endmodule

// File: rtl/trp_slot.sv
module trp_slot (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic fire,
  output logic in_ready,
  output logic pending
);
  logic accept;
  logic pending_d;

  assign accept = in_valid && in_ready;

  always_comb begin
    pending_d = pending;
    if (fire)        pending_d = 1'b0;
    else if (accept) pending_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      pending  <= pending_d;
      in_ready <= !pending_d;
    end
  end
endmodule

// File: rtl/trp_fire.sv
module trp_fire
  import torpedo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pending,
  input  logic     interruptible,
  input  logic     od_done,
  output logic     fire,
  output trp_evt_t evt_q
);
  assign fire = pending && interruptible;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q.fire   <= fire;
      evt_q.squash <= fire && od_done;
    end
  end
endmodule

// File: rtl/torpedo_arbiter.sv
module torpedo_arbiter
  import torpedo_pkg::*;
#(
  parameter int unsigned OPC_W    = 3,
  parameter logic [OPC_W-1:0] MOVE_OPC = 3'b001,
  parameter int unsigned WAIT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trp_valid,
  output logic              trp_ready,
  input  logic              od_valid,
  input  logic [OPC_W-1:0]  od_opcode,
  input  logic              od_intr,
  input  logic              od_pred,
  input  logic              od_outer_pos,
  input  logic [WAIT_W-1:0] od_wait,
  input  logic              od_done,
  output logic              loop_clear,
  output logic              od_squash
);
  logic     interruptible;
  logic     pending;
  logic     fire;
  trp_evt_t evt_q;

  trp_eligibility #(.OPC_W(OPC_W), .MOVE_OPC(MOVE_OPC), .WAIT_W(WAIT_W)) u_elig (
    .od_valid      (od_valid),
    .od_opcode     (od_opcode),
    .od_intr       (od_intr),
    .od_pred       (od_pred),
    .od_outer_pos  (od_outer_pos),
    .od_wait       (od_wait),
    .interruptible (interruptible)
  );

  trp_slot u_slot (
    .clk      (clk),
    .rst      (rst),
    .in_valid (trp_valid),
    .fire     (fire),
    .in_ready (trp_ready),
    .pending  (pending)
  );

  trp_fire u_fire (
    .clk           (clk),
    .rst           (rst),
    .pending       (pending),
    .interruptible (interruptible),
    .od_done       (od_done),
    .fire          (fire),
    .evt_q         (evt_q)
  );

  assign loop_clear = evt_q.fire;
  assign od_squash  = evt_q.squash;
endmodule

// File: rtl/torpedo_arbiter_checker.sv
module torpedo_arbiter_checker #(
  parameter int unsigned OPC_W    = 3,
  parameter logic [OPC_W-1:0] MOVE_OPC = 3'b001,
  parameter int unsigned WAIT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              trp_valid,
  input logic              trp_ready,
  input logic              od_valid,
  input logic [OPC_W-1:0]  od_opcode,
  input logic              od_intr,
  input logic              od_pred,
  input logic              od_outer_pos,
  input logic [WAIT_W-1:0] od_wait,
  input logic              od_done,
  input logic              loop_clear,
  input logic              od_squash
);
  logic elig;
  assign elig = od_valid && (od_opcode == MOVE_OPC) && od_intr && od_pred &&
                od_outer_pos && (od_wait != '0);

  AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (trp_valid && trp_ready) |=> !trp_ready); // R2
  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!trp_ready && !elig) |=> (!loop_clear && !trp_ready)); // R3
  AST_FIRE_WHEN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    (!trp_ready && elig) |=> loop_clear); // R5
  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    loop_clear |=> !loop_clear); // R5
  AST_READY_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    loop_clear |-> trp_ready); // R6
  AST_CLEAR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (trp_ready && !loop_clear) |=> !loop_clear); // R7
  AST_SQUASH_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    od_squash |-> loop_clear); // R8
  AST_SQUASH_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (!trp_ready && elig && od_done) |=> od_squash); // R8
endmodule

bind torpedo_arbiter torpedo_arbiter_checker #(
  .OPC_W(OPC_W), .MOVE_OPC(MOVE_OPC), .WAIT_W(WAIT_W)
) u_chk (.*);

// File: tb/torpedo_arbiter_test.sv
module torpedo_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trp_valid = 1'b0;
  logic       trp_ready;
  logic       od_valid = 1'b0;
  logic [2:0] od_opcode = 3'b000;
  logic       od_intr = 1'b0;
  logic       od_pred = 1'b0;
  logic       od_outer_pos = 1'b0;
  logic [2:0] od_wait = 3'b000;
  logic       od_done = 1'b0;
  logic       loop_clear;
  logic       od_squash;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  clr;
    logic  rdy;
    logic  sq;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  torpedo_arbiter uut (
    .clk(clk), .rst(rst), .trp_valid(trp_valid), .trp_ready(trp_ready),
    .od_valid(od_valid), .od_opcode(od_opcode), .od_intr(od_intr),
    .od_pred(od_pred), .od_outer_pos(od_outer_pos), .od_wait(od_wait),
    .od_done(od_done), .loop_clear(loop_clear), .od_squash(od_squash)
  );

  // Monitor: one expected item per clock, compared after the edge settles
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (loop_clear !== e.clr || trp_ready !== e.rdy || od_squash !== e.sq) begin
        n_fail++;
        $display("FAIL %s: clear/ready/squash got %b%b%b expected %b%b%b",
                 e.tag, loop_clear, trp_ready, od_squash, e.clr, e.rdy, e.sq);
      end
    end
  end

  // Driver: apply one cycle of stimulus, queue what must follow that edge
  task automatic step(input logic v, input logic dv, input logic [2:0] opc,
                      input logic ib, input logic pr, input logic op,
                      input logic [2:0] wt, input logic dn,
                      input logic eclr, input logic erdy, input logic esq,
                      input string tag);
    exp_t e;
    @(negedge clk);
    trp_valid = v; od_valid = dv; od_opcode = opc; od_intr = ib;
    od_pred = pr; od_outer_pos = op; od_wait = wt; od_done = dn;
    @(posedge clk);
    #1;
    e.clr = eclr; e.rdy = erdy; e.sq = esq; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (loop_clear !== 1'b0 || trp_ready !== 1'b1 || od_squash !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %b%b%b expected 010", loop_clear, trp_ready, od_squash);
    end
    rst = 1'b0;

    // R1 idle after reset
    step(0, 0, 3'b000, 0, 0, 0, 3'b000, 0, 0, 1, 0, "R1 idle");
    // R7 eligible deck but nothing pending
    step(0, 1, 3'b001, 1, 1, 1, 3'b010, 0, 0, 1, 0, "R7 no pending");
    step(0, 1, 3'b001, 1, 1, 1, 3'b111, 1, 0, 1, 0, "R7 no pending done");

    // R2 then R5: accept, fire, single pulse
    step(1, 1, 3'b001, 1, 1, 1, 3'b010, 0, 0, 0, 0, "R2 accept");
    step(0, 1, 3'b001, 1, 1, 1, 3'b010, 0, 1, 1, 0, "R5 fire");
    step(0, 1, 3'b001, 1, 1, 1, 3'b010, 0, 0, 1, 0, "R5 single pulse");

    // R3 each missing condition holds the request
    step(1, 1, 3'b001, 0, 1, 1, 3'b010, 0, 0, 0, 0, "R2 accept blocked");
    step(0, 1, 3'b001, 0, 1, 1, 3'b111, 0, 0, 0, 0, "R3 intr low");
    step(0, 1, 3'b010, 1, 1, 1, 3'b111, 0, 0, 0, 0, "R3 not move");
    step(0, 1, 3'b001, 1, 0, 1, 3'b111, 0, 0, 0, 0, "R3 pred false");
    step(0, 1, 3'b001, 1, 1, 0, 3'b111, 0, 0, 0, 0, "R3 outer zero");
    step(0, 1, 3'b001, 1, 1, 1, 3'b000, 1, 0, 0, 0, "R3 not waiting");
    step(0, 0, 3'b001, 1, 1, 1, 3'b111, 0, 0, 0, 0, "R3 deck empty");
    step(0, 1, 3'b001, 1, 1, 1, 3'b100, 0, 1, 1, 0, "R4 dout wait fires");

    // R4 token-wait alone, then input-data wait alone
    step(1, 0, 3'b000, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R2 accept token");
    step(0, 1, 3'b001, 1, 1, 1, 3'b001, 0, 1, 1, 0, "R4 token wait fires");
    step(1, 0, 3'b000, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R2 accept");
    step(0, 1, 3'b001, 1, 1, 1, 3'b010, 0, 1, 1, 0, "R4 din wait fires");

    // R2 valid held high while pending is ignored; R6 back-to-back accept
    step(1, 0, 3'b000, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R2 accept");
    step(1, 1, 3'b001, 1, 1, 0, 3'b010, 0, 0, 0, 0, "R2 valid ignored");
    step(1, 1, 3'b001, 1, 1, 1, 3'b010, 0, 1, 1, 0, "R6 fire ready back");
    step(1, 0, 3'b000, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R6 immediate reaccept");

    // R8 completion coincides: clear still fires with squash
    step(0, 1, 3'b001, 1, 1, 1, 3'b010, 1, 1, 1, 1, "R8 abort beats done");
    step(0, 0, 3'b000, 0, 0, 0, 3'b000, 1, 0, 1, 0, "R8 no squash idle");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule